// File: doc/BRIEF.md
# Round-Robin Next-Requester Picker

This block chooses which of N requesters is served next in a round-robin rotation. A register holds the requester that currently owns the slot, as a one-hot vector. Combinational logic compares that vector with the live request vector and produces a one-hot vector for the next owner. The search starts at the index just above the current owner and moves upward. It wraps from the highest index back to index 0. Requesters whose request bit is clear are skipped. The current owner is examined last, so it is picked again only when no other requester is asking.

The selection logic is a linear chain of gates that the generator unrolls over a doubled copy of the request vector. It uses no subtractor and no wide borrow path, and it has a fixed number of gates for each bit, so it scales to wide one-hot vectors. When the `advance_i` strobe is high and some requester is asking, the chosen vector is loaded into the owner register at the clock edge.

Top module: `rr_next_picker`

## Requirements
- R1: Every set bit of `nxt_o` is also set in `req_i`.
- R2: At most one bit of `nxt_o` is set, and at most one bit of `cur_o` is set.
- R3: Bit 0 of a vector is its rightmost bit. The search begins at the index one above the current owner and moves upward. With N=8, owner bit 2 and `req_i`=01100000, `nxt_o` is 00100000.
- R4: The search wraps from bit N-1 to bit 0. With N=8, owner bit 6 and `req_i`=00001010, `nxt_o` is 00000010.
- R5: The current owner is examined after every other index. It is selected only when it is the only requester.
- R6: `nxt_valid_o` is high exactly when `req_i` has at least one bit set. When no request is present, `nxt_o` is all zeros.
- R7: When `cur_o` is all zeros, the search begins at bit 0, as it would if the owner were bit N-1.
- R8: While `rst_ni` is low, and after it rises, `cur_o` is all zeros until the first load.
- R9: On a clock edge where `advance_i` and `nxt_valid_o` are both high, `cur_o` takes the value `nxt_o` had just before that edge.
- R10: On a clock edge where `advance_i` is low, or where no request is present, `cur_o` keeps its value.
- R11: The width N is a parameter. The selection is correct at a width that is not a power of two, for example N=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Request vector, one bit per requester |
| advance_i | input | 1 | Load the selected requester into the owner register |
| cur_o | output | N | One-hot owner register (all zeros after reset) |
| nxt_o | output | N | One-hot next owner, combinational |
| nxt_valid_o | output | 1 | High when some requester is asking |

## Verification
A wrong owner register shows up on `nxt_o` in the same cycle, because the search start moves with it. The corrupted owner also propagates into every later grant, so the bench tracks its own model of the owner and checks both `cur_o` and `nxt_o` on every clock. A break in the hit chain shows up at once in one of two ways: two bits set in `nxt_o`, or a grant to a requester that is not asking. A wrong arming point shows up as a requester being skipped. Each owner position is used as a starting point against random request patterns at both widths, so such a fault appears within a few cycles of the first request pattern that reaches it.

// File: rtl/rrp_pkg.sv
package rrp_pkg;
  // Ring position p in the doubled search path maps to requester bit p mod n.
  function automatic int ring_bit(input int pos, input int n);
    return pos % n;
  endfunction

  // Position p in the doubled path is armed by owner bit p-1 only in the first lap.
  function automatic bit owner_arms(input int pos, input int n);
    return (pos >= 1) && (pos <= n);
  endfunction
endpackage

// File: rtl/rrp_arm_chain.sv
module rrp_arm_chain #(
  parameter int N = 8
) (
  input  logic [N-1:0]   cur_i,
  output logic [2*N-1:0] arm_o
);
  localparam int W = 2 * N;

  // An empty owner vector arms the path from position 0.
  assign arm_o[0] = ~(|cur_i);

  for (genvar p = 1; p < W; p++) begin : g_arm
    if (rrp_pkg::owner_arms(p, N)) begin : g_seed
      assign arm_o[p] = arm_o[p-1] | cur_i[p-1];
    end else begin : g_pass
      assign arm_o[p] = arm_o[p-1];
    end
  end
endmodule

// File: rtl/rrp_first_hit.sv
module rrp_first_hit #(
  parameter int N = 8
) (
  input  logic [2*N-1:0] arm_i,
  input  logic [N-1:0]   req_i,
  output logic [2*N-1:0] hit_o
);
  localparam int W = 2 * N;

  logic [W-1:0] taken;

  assign taken[0] = 1'b0;

  for (genvar p = 0; p < W; p++) begin : g_hit
    assign hit_o[p] = arm_i[p] & req_i[rrp_pkg::ring_bit(p, N)] & ~taken[p];
    if (p < W - 1) begin : g_link
      assign taken[p+1] = taken[p] | hit_o[p];
    end
  end
endmodule

// File: rtl/rrp_fold.sv
module rrp_fold #(
  parameter int N = 8
) (
  input  logic [2*N-1:0] hit_i,
  output logic [N-1:0]   gnt_o,
  output logic           any_o
);
  for (genvar b = 0; b < N; b++) begin : g_fold
    assign gnt_o[b] = hit_i[b] | hit_i[b+N];
  end

  assign any_o = |gnt_o;
endmodule

// File: rtl/rrp_hold_reg.sv
module rrp_hold_reg #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (load_i) begin
      q_o <= d_i;
    end
  end
endmodule

// File: rtl/rr_next_picker.sv
module rr_next_picker #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         advance_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] nxt_o,
  output logic         nxt_valid_o
);
  localparam int W = 2 * N;

  logic [W-1:0] arm_path;
  logic [W-1:0] hit_path;
  logic         load_en;

  rrp_arm_chain #(.N(N)) arm_i (
    .cur_i (cur_o),
    .arm_o (arm_path)
  );

  rrp_first_hit #(.N(N)) hit_i (
    .arm_i (arm_path),
    .req_i (req_i),
    .hit_o (hit_path)
  );

  rrp_fold #(.N(N)) fold_i (
    .hit_i (hit_path),
    .gnt_o (nxt_o),
    .any_o (nxt_valid_o)
  );

  assign load_en = advance_i & nxt_valid_o;

  rrp_hold_reg #(.N(N)) own_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_en),
    .d_i    (nxt_o),
    .q_o    (cur_o)
  );
endmodule

// File: rtl/rr_next_picker_chk.sv
module rr_next_picker_chk #(
  parameter int N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] req_i,
  input logic         advance_i,
  input logic [N-1:0] cur_o,
  input logic [N-1:0] nxt_o,
  input logic         nxt_valid_o
);
  // R1
  grant_in_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nxt_o & ~req_i) == '0);

  // R2
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(nxt_o) && $onehot0(cur_o));

  // R5
  sole_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_o != '0 && req_i == cur_o) |-> nxt_o == cur_o);

  // R5
  owner_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_i & ~cur_o) != '0) |-> (nxt_o & cur_o) == '0);

  // R6
  valid_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nxt_valid_o == (req_i != '0) && (nxt_valid_o || nxt_o == '0));

  // R9
  load_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && nxt_valid_o) |=> cur_o == $past(nxt_o));

  // R10
  hold_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!advance_i || !nxt_valid_o) |=> $stable(cur_o));
endmodule

bind rr_next_picker rr_next_picker_chk #(.N(N)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .advance_i   (advance_i),
  .cur_o       (cur_o),
  .nxt_o       (nxt_o),
  .nxt_valid_o (nxt_valid_o)
);

// File: tb/rr_next_picker_tb.sv
module rr_next_picker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       adv = 1'b0;
  logic [7:0] req8 = '0;
  logic [4:0] req5 = '0;
  logic [7:0] cur8, nxt8;
  logic [4:0] cur5, nxt5;
  logic       val8, val5;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] mcur8 = '0;
  logic [31:0] mcur5 = '0;

  always #10 clk = ~clk;

  rr_next_picker #(.N(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req8), .advance_i(adv),
    .cur_o(cur8), .nxt_o(nxt8), .nxt_valid_o(val8)
  );

  rr_next_picker #(.N(5)) dut_odd_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req5), .advance_i(adv),
    .cur_o(cur5), .nxt_o(nxt5), .nxt_valid_o(val5)
  );

  // Behavioural model: walk the ring one index at a time.
  function automatic logic [31:0] model_next(input logic [31:0] cur,
                                             input logic [31:0] req, input int n);
    int start = 0;
    for (int i = 0; i < n; i++) if (cur[i]) start = i + 1;
    for (int s = 0; s < n; s++) begin
      int idx = (start + s) % n;
      if (req[idx]) return 32'd1 << idx;
    end
    return '0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, compare before the rising edge, then update the model.
  task automatic step(input logic [7:0] r8, input logic [4:0] r5, input logic a);
    logic [31:0] e8, e5;
    @(negedge clk);
    req8 = r8; req5 = r5; adv = a;
    #5;
    e8 = model_next(mcur8, {24'd0, r8}, 8);
    e5 = model_next(mcur5, {27'd0, r5}, 5);
    check("R3 next N=8", {24'd0, nxt8}, e8);
    check("R11 next N=5", {27'd0, nxt5}, e5);
    check("R1 grant subset", {24'd0, nxt8 & ~r8}, '0);
    check("R2 one-hot", $countones(nxt8) <= 1, 32'd1);
    check("R6 valid N=8", {31'd0, val8}, {31'd0, r8 != '0});
    check("R6 valid N=5", {31'd0, val5}, {31'd0, r5 != '0});
    check("R9 owner N=8", {24'd0, cur8}, mcur8);
    check("R11 owner N=5", {27'd0, cur5}, mcur5);
    @(posedge clk);
    if (a && r8 != '0) mcur8 = e8;
    if (a && r5 != '0) mcur5 = e5;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R8 reset owner", {24'd0, cur8}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    // R7: empty owner starts the search at bit 0
    step(8'b1000_0001, 5'b10001, 1'b0);
    check("R7 start at bit 0", {24'd0, nxt8}, 32'b0000_0001);
    // R3 example
    step(8'b0000_0100, 5'b00100, 1'b1);
    step(8'b0110_0000, 5'b00000, 1'b0);
    check("R3 skip idle", {24'd0, nxt8}, 32'b0010_0000);
    // R4 wraparound example
    step(8'b0100_0000, 5'b10000, 1'b1);
    step(8'b0000_1010, 5'b00010, 1'b0);
    check("R4 wrap", {24'd0, nxt8}, 32'b0000_0010);
    // R5: owner is last in order
    step(8'b0000_1010, 5'b00010, 1'b1);
    step(8'b0000_0010, 5'b00010, 1'b0);
    check("R5 sole owner", {24'd0, nxt8}, 32'b0000_0010);
    step(8'b0000_0011, 5'b00011, 1'b0);
    check("R5 other first", {24'd0, nxt8}, 32'b0000_0001);
    // R6 / R10: no request, advance held
    step(8'b0000_0000, 5'b00000, 1'b1);
    check("R6 zero grant", {24'd0, nxt8}, '0);
    step(8'b0000_0000, 5'b00000, 1'b0);
    check("R10 hold owner", {24'd0, cur8}, 32'b0000_0010);
    step(8'b1111_0000, 5'b11100, 1'b0);
    check("R10 no advance", {24'd0, cur8}, 32'b0000_0010);
    // Every owner position against random requests
    for (int p = 0; p < 8; p++) begin
      step(8'd1 << p, 5'd1 << (p % 5), 1'b1);
      for (int k = 0; k < 12; k++) step(8'($urandom), 5'($urandom), 1'b0);
    end
    for (int k = 0; k < 400; k++)
      step(8'($urandom) & 8'($urandom), 5'($urandom), 1'($urandom));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule